// File: doc/BRIEF.md
# Two-Channel Pulse-Width Modulator

This block drives two pulse-width modulated pins from one shared PWM clock. Each channel has two registers. The period register sets the number of PWM ticks in one cycle of the waveform. The on-count register sets how many of those ticks are high. A single packed control word holds eight bits per channel. For each channel it enables the channel, chooses the idle (silence) level, inverts the output, and selects between two algorithms. The first is a mark/space waveform: one solid high pulse, then low for the rest of the period. The second is a dithered mode that spreads the high ticks as evenly as it can across the period.

Software reaches the registers over a plain register bus. The bus has an address, a write strobe, write data and combinational read data. The PWM clock comes from outside as a clock-enable tick, and all waveform logic advances only on cycles where the tick is high. The serializer-select, repeat-last and queue-select bits are stored and read back, but they have no effect on the pins.

Top module: `twin_pwm`

## Requirements
- R1: Register map and readback. The control word is at address 0x00. Channel 1 period is at 0x10 and its on-count at 0x14. Channel 2 period is at 0x20 and its on-count at 0x24. Period and on-count registers keep the low CNT_W bits of the write data and read back zero-extended. Every other address reads 0. All registers reset to 0.
- R2: Control-word layout. Channel 1 uses bits 7:0 and channel 2 uses the same layout in bits 15:8. Within a channel's byte: bit0 enable, bit1 serializer select, bit2 repeat-last, bit3 silence level, bit4 invert, bit5 queue select, bit6 queue clear, bit7 mark/space select. The queue-clear bits (6 and 14) and bits 31:16 always read 0; the other bits read back as written.
- R3: A disabled channel drives its pin at its silence bit, whatever the invert bit holds.
- R4: In mark/space mode with period P>0 and on-count D≤P, the pin after the k-th tick since enable (k counting from 0) is high exactly when k mod P < D.
- R5: In dithered mode with period P>0 and on-count D≤P, the pin after the k-th tick since enable is high exactly when floor((k+1)·D/P) > floor(k·D/P).
- R6: An on-count above the period acts as the period, so the channel is high on every tick in both modes.
- R7: An enabled channel whose period is 0 drives its silence level.
- R8: The invert bit inverts an enabled channel's waveform. Between enable and the first tick, an enabled channel shows the inverted low level, which is the invert bit itself.
- R9: In mark/space mode, a period or on-count written in the middle of a period takes effect only at the start of the next period.
- R10: The serializer-select, repeat-last and queue-select bits leave the pin waveform unchanged.
- R11: The waveform state advances only on cycles with tick high; on other cycles the pins hold.
- R12: The channels run independently of each other at the same time. Disabling and then re-enabling a channel restarts its waveform at tick 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | PWM clock enable; waveform state advances only when high |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe; writes bus_wdata at bus_addr on the clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| pwm_o | output | NCH | PWM pins; bit 0 is channel 1 |

## Verification
A small configuration with an 8-bit counter is used. Every period from 1 to 7 is paired with every on-count from 0 to one above the period. Each pair runs in both algorithms at the same time, one algorithm per channel, and is then run again with the channels swapped and the outputs inverted. This separates the mark/space arithmetic from the dithered arithmetic and checks the on-count clamp at its edge.

Separate runs cover further cases:
- a tick that is low one cycle in three, which shows that state advances only on ticks;
- the storage-only control bits set, which must not change the waveform;
- a period of 0, and a disabled channel with its invert bit set, which separate the silence path from the inverted waveform;
- an on-count written mid-period, which must wait for the next period;
- a disable and re-enable, which must restart the waveform.

// File: rtl/twin_pwm_pkg.sv
package twin_pwm_pkg;

  // One channel's byte of the control word; field order is bit 7 down to bit 0.
  typedef struct packed {
    logic ms_sel;      // 1: mark/space, 0: dithered
    logic q_clear;     // never stored, reads 0
    logic q_sel;       // stored only
    logic invert;      // output inversion
    logic silence;     // idle level
    logic rpt_last;    // stored only
    logic serial_sel;  // stored only
    logic enable;
  } chan_ctrl_t;

  localparam int CTRL_BITS = 8;
  localparam int CH_STRIDE = 16;
  localparam int DAT_OFS   = 4;

  function automatic chan_ctrl_t scrub_ctrl(logic [CTRL_BITS-1:0] raw);
    chan_ctrl_t c;
    c = chan_ctrl_t'(raw);
    c.q_clear = 1'b0;
    return c;
  endfunction

endpackage

// File: rtl/twin_pwm_regs.sv
module twin_pwm_regs
  import twin_pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int NCH    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output chan_ctrl_t        ctrl_o [NCH],
  output logic [CNT_W-1:0]  rng_o  [NCH],
  output logic [CNT_W-1:0]  dat_o  [NCH]
);

  localparam logic [ADDR_W-1:0] CTRL_A = '0;

  chan_ctrl_t       ctrl_q [NCH];
  logic [CNT_W-1:0] rng_q  [NCH];
  logic [CNT_W-1:0] dat_q  [NCH];

  function automatic logic [ADDR_W-1:0] rng_addr(int ch);
    return ADDR_W'(CH_STRIDE * (ch + 1));
  endfunction

  function automatic logic [ADDR_W-1:0] dat_addr(int ch);
    return ADDR_W'(CH_STRIDE * (ch + 1) + DAT_OFS);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NCH; k++) begin
        ctrl_q[k] <= '0;
        rng_q[k]  <= '0;
        dat_q[k]  <= '0;
      end
    end else if (wr_en) begin
      for (int k = 0; k < NCH; k++) begin
        if (addr == CTRL_A) ctrl_q[k] <= scrub_ctrl(wdata[CTRL_BITS*k +: CTRL_BITS]);
        if (addr == rng_addr(k)) rng_q[k] <= wdata[CNT_W-1:0];
        if (addr == dat_addr(k)) dat_q[k] <= wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NCH; k++) begin
      if (addr == CTRL_A) rdata[CTRL_BITS*k +: CTRL_BITS] = ctrl_q[k];
      if (addr == rng_addr(k)) rdata = DATA_W'(rng_q[k]);
      if (addr == dat_addr(k)) rdata = DATA_W'(dat_q[k]);
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_out
      assign ctrl_o[gi] = ctrl_q[gi];
      assign rng_o[gi]  = rng_q[gi];
      assign dat_o[gi]  = dat_q[gi];

      // R1: a period write lands in the register on the next cycle
      assert_range_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == rng_addr(gi)) |=> (rng_q[gi] == $past(wdata[CNT_W-1:0])));
    end
  endgenerate

endmodule

// File: rtl/twin_pwm_chan.sv
module twin_pwm_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             ms_sel,
  input  logic             invert,
  input  logic             silence,
  input  logic [CNT_W-1:0] rng,
  input  logic [CNT_W-1:0] dat,
  output logic             pin
);

  logic [CNT_W-1:0] cnt_q, acc_q, act_rng_q, act_dat_q;
  logic             raw_q;

  logic [CNT_W-1:0] eff_dat, use_rng, use_dat;
  logic [CNT_W:0]   sum;
  logic             active, at_start, wrap, hit;

  always_comb begin
    eff_dat  = (dat > rng) ? rng : dat;
    active   = en && (rng != '0);
    at_start = (cnt_q == '0);
    use_rng  = at_start ? rng : act_rng_q;
    use_dat  = at_start ? eff_dat : act_dat_q;
    wrap     = (cnt_q == use_rng - CNT_W'(1));
    sum      = {1'b0, acc_q} + {1'b0, eff_dat};
    hit      = (sum >= {1'b0, rng});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      acc_q     <= '0;
      act_rng_q <= '0;
      act_dat_q <= '0;
      raw_q     <= 1'b0;
    end else if (!active) begin
      cnt_q     <= '0;
      acc_q     <= '0;
      raw_q     <= 1'b0;
      act_rng_q <= rng;
      act_dat_q <= eff_dat;
    end else if (tick) begin
      if (ms_sel) begin
        raw_q <= (cnt_q < use_dat);
        cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
        acc_q <= '0;
        if (at_start) begin
          act_rng_q <= rng;
          act_dat_q <= eff_dat;
        end
      end else begin
        raw_q <= hit;
        acc_q <= hit ? CNT_W'(sum - {1'b0, rng}) : CNT_W'(sum);
        cnt_q <= '0;
      end
    end
  end

  assign pin = active ? (raw_q ^ invert) : silence;

  // R11: without a tick the waveform bit holds
  assert_hold_without_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(raw_q));

  // R4: the mark/space position stays inside the latched period
  assert_count_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q < act_rng_q));

  // R9: the latched on-count cannot change in the middle of a period
  assert_update_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ms_sel && cnt_q != '0) |=> $stable(act_dat_q));

  // R5: the dither remainder stays below the period while the period is steady
  assert_accum_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ms_sel && acc_q < rng) |=> ((acc_q < rng) || (rng != $past(rng))));

endmodule

// File: rtl/twin_pwm.sv
module twin_pwm
  import twin_pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int NCH    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_o
);

  chan_ctrl_t       ctrl [NCH];
  logic [CNT_W-1:0] rng  [NCH];
  logic [CNT_W-1:0] dat  [NCH];
  logic [NCH-1:0]   unused_ctrl_bits;

  twin_pwm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .NCH(NCH)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .wr_en (bus_we),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .ctrl_o(ctrl),
    .rng_o (rng),
    .dat_o (dat)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_chan
      assign unused_ctrl_bits[gi] = ^{ctrl[gi].q_clear, ctrl[gi].q_sel,
                                      ctrl[gi].rpt_last, ctrl[gi].serial_sel};
      twin_pwm_chan #(.CNT_W(CNT_W)) u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .en     (ctrl[gi].enable),
        .ms_sel (ctrl[gi].ms_sel),
        .invert (ctrl[gi].invert),
        .silence(ctrl[gi].silence),
        .rng    (rng[gi]),
        .dat    (dat[gi]),
        .pin    (pwm_o[gi])
      );
    end
  endgenerate

endmodule

// File: tb/twin_pwm_bench.sv
`timescale 1ns/1ps
module twin_pwm_bench;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [1:0]    pwm_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  twin_pwm #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .NCH(2)) u_twin_pwm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [AW-1:0] a, logic [DW-1:0] exp);
    bus_addr = a;
    #0.5;
    chk(tag, bus_rdata, exp);
  endtask

  function automatic bit wave(bit ms, int r, int d, int k);
    int dc;
    dc = (d > r) ? r : d;
    if (ms) return ((k % r) < dc);
    return (((k + 1) * dc) / r) != ((k * dc) / r);
  endfunction

  function automatic bit expect_pin(bit ms, int r, int d, bit p, bit s, int j);
    if (r == 0) return s;
    if (j == 0) return p;
    return wave(ms, r, d, j - 1) ^ p;
  endfunction

  function automatic string tag_of(bit ms, int r, int d, string ovr);
    if (ovr != "") return ovr;
    if (d > r) return "R6";
    return ms ? "R4" : "R5";
  endfunction

  function automatic logic [7:0] ctl_byte(bit ms, bit p, bit s, logic [7:0] extra);
    return {ms, 2'b00, p, s, 3'b001} | extra;
  endfunction

  task automatic run_pair(int r0, int d0, bit m0, bit p0, bit s0,
                          int r1, int d1, bit m1, bit p1, bit s1,
                          logic [7:0] extra, bit gated, int n, string ovr);
    int j;
    wr(8'h00, 32'h0);
    wr(8'h10, DW'(r0)); wr(8'h14, DW'(d0));
    wr(8'h20, DW'(r1)); wr(8'h24, DW'(d1));
    wr(8'h00, {16'h0, ctl_byte(m1, p1, s1, extra), ctl_byte(m0, p0, s0, extra)});
    j = 0;
    chk(tag_of(m0, r0, d0, ovr), pwm_o[0], expect_pin(m0, r0, d0, p0, s0, 0));
    chk(tag_of(m1, r1, d1, ovr), pwm_o[1], expect_pin(m1, r1, d1, p1, s1, 0));
    for (int c = 0; c < n; c++) begin
      tick = gated ? ((c % 3) != 2) : 1'b1;
      @(negedge clk);
      if (tick) j++;
      chk(tag_of(m0, r0, d0, ovr), pwm_o[0], expect_pin(m0, r0, d0, p0, s0, j));
      chk(tag_of(m1, r1, d1, ovr), pwm_o[1], expect_pin(m1, r1, d1, p1, s1, j));
    end
    tick = 1'b1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit seq [6];
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // reset state (R1)
    chk("R1 reset pins", {30'h0, pwm_o}, 32'h0);
    rd_chk("R1 reset ctrl", 8'h00, 0);
    rd_chk("R1 reset rng1", 8'h10, 0);
    rd_chk("R1 reset dat2", 8'h24, 0);

    // R1 map and truncation
    @(negedge clk);
    wr(8'h10, 32'h1A5); wr(8'h14, 32'h3C); wr(8'h20, 32'h77); wr(8'h24, 32'hF01);
    rd_chk("R1 rng1", 8'h10, 32'hA5);
    rd_chk("R1 dat1", 8'h14, 32'h3C);
    rd_chk("R1 rng2", 8'h20, 32'h77);
    rd_chk("R1 dat2", 8'h24, 32'h01);
    rd_chk("R1 unmapped", 8'h18, 0);
    @(negedge clk);

    // R2 control readback masking
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl all ones", 8'h00, 32'h0000_BFBF);
    @(negedge clk);
    wr(8'h00, 32'h0000_2A55);
    rd_chk("R2 ctrl pattern", 8'h00, 32'h0000_2A15);
    @(negedge clk);

    // R3 disabled channels: silence level, invert ignored
    wr(8'h00, 32'h0000_1018);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk("R3 ch1 silence high", pwm_o[0], 1'b1);
      chk("R3 ch2 silence low", pwm_o[1], 1'b0);
    end

    // R4 R5 R6 R12: full sweep, both algorithms side by side, then swapped and inverted (R8)
    for (int r = 1; r <= 7; r++) begin
      for (int d = 0; d <= r + 1; d++) begin
        run_pair(r, d, 1'b1, 1'b0, 1'b0, r, d, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 2*r + 2, "");
        run_pair(r, d, 1'b0, 1'b1, 1'b0, r, d, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 2*r + 2, "R8");
      end
    end

    // R7 zero period forces silence
    run_pair(0, 3, 1'b1, 1'b0, 1'b1, 0, 2, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 6, "R7");

    // R10 storage-only bits leave the waveform unchanged
    run_pair(5, 2, 1'b1, 1'b0, 1'b0, 6, 4, 1'b0, 1'b0, 1'b0, 8'h26, 1'b0, 14, "R10");

    // R11 gated tick
    run_pair(4, 3, 1'b1, 1'b0, 1'b0, 5, 2, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 24, "R11");

    // R12 restart: run mid-period, then disable and enable again
    run_pair(5, 2, 1'b1, 1'b0, 1'b0, 7, 3, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 3, "R12");
    run_pair(5, 2, 1'b1, 1'b0, 1'b0, 7, 3, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 4, "R12");

    // R9 mid-period on-count change waits for next period
    run_pair(4, 1, 1'b1, 1'b0, 1'b0, 3, 1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 2, "R9");
    wr(8'h14, 32'd3);
    seq = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
    for (int i = 0; i < 6; i++) begin
      if (i > 0) @(negedge clk);
      chk("R9 deferred on-count", pwm_o[0], seq[i]);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule